// File: doc/BRIEF.md
# Legacy Paravirtual Device Register Window

This block is the I/O-space register window that a guest driver uses to configure a legacy paravirtualized device. A simple read/write bus carries the byte offset of the register, a size code and a data word. The common area holds the feature masks, a queue selector with the per-queue ring frame number, ring size and interrupt vector, a doorbell, the device status byte, an interrupt status byte, and a configuration-change vector. Any offset past the end of the common area goes, rebased to zero, to a device-specific configuration port.

Writing zero to the status byte or to the ring frame number of the selected queue returns the whole window to its reset state, and the block emits a one-cycle reset pulse that tells the device behind it to reset. When message interrupts are enabled, the two vector registers are part of the common area, which then ends at offset 24. When they are disabled, the common area ends at 20 and the vector offsets belong to the device area. Read data comes back on a registered response one cycle after the request.

Top module: `pvdev_regwin`

## Requirements
- R1: After reset, guest features, queue select, status, interrupt status and every ring frame number read as 0, and the configuration vector and every queue vector read as 16'hFFFF.
- R2: A read of offset 0 returns `dev_features` ORed with bit 24 (notify on empty), bit 28 (indirect descriptors) and bit 30 (poison marker). Writes to offset 0 have no effect.
- R3: A write to offset 4 stores the 32-bit guest feature mask. If bit 30 of the written value is set, the stored value is instead `fallback_mask` when `fallback_valid` is 1, and 0 otherwise.
- R4: A write to offset 14 changes the queue select only when the full 32-bit value is below NQ. Otherwise the write is ignored. A read of offset 14 returns the current select.
- R5: Offsets 8 (ring frame number, 32-bit), 12 (ring size, read-only, taken from lane `sel` of `queue_sizes`) and 22 (queue vector) all act on the currently selected queue.
- R6: A write of 0 to offset 8 stores nothing. It pulses `dev_reset_o` for one cycle in the next cycle and returns all state to the R1 values.
- R7: A write to offset 18 stores the low 8 bits as the status. If those 8 bits are zero, the write pulses `dev_reset_o` and restores the R1 state.
- R8: `intr_set` bits are ORed into the interrupt status byte (offset 19). A read of offset 19 returns the byte and clears it. A bit set in the same cycle as the read is kept. `irq_o` equals bit 0 of the byte while message interrupts are disabled, and is 0 while they are enabled.
- R9: A write to offset 16 raises `doorbell_o` for exactly one cycle, in the cycle after the write, with `doorbell_q` holding the low 16 bits of the written value.
- R10: When message interrupts are enabled, offset 20 is the configuration vector and offset 22 is the queue vector. A written value of NVEC or more is stored as 16'hFFFF.
- R11: Reads of unmapped offsets in the common area return 32'hFFFFFFFF. These offsets are 1–3, 5–7, 9–11, 13, 15–17 and 21/23, and the notify offset 16 also reads this way. Writes to unmapped or read-only offsets (0, 12, 19) change nothing.
- R12: An access at or beyond offset 24 (message interrupts enabled) or 20 (disabled) appears in the same cycle on the `dcfg_*` port, with the offset rebased to zero and with the same write flag, size and data. Its read data is returned as the response.
- R13: Every read produces `rsp_valid` with data exactly one cycle later. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code (0 byte, 1 word, 2 dword), passed to the device port |
| req_addr | input | AW | Byte offset into the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response strobe |
| rsp_rdata | output | 32 | Read response data |
| msg_int_en | input | 1 | Message interrupts enabled |
| dev_features | input | 32 | Native feature mask of the device |
| fallback_valid | input | 1 | A fallback feature mask is available |
| fallback_mask | input | 32 | Feature mask used when the guest sets the poison bit |
| queue_sizes | input | NQ*16 | Ring size of each queue, queue i in bits [16i+15:16i] |
| intr_set | input | 8 | Interrupt status bits to set |
| irq_o | output | 1 | Level interrupt for the non-message mode |
| dev_reset_o | output | 1 | One-cycle device reset pulse |
| doorbell_o | output | 1 | One-cycle queue notify pulse |
| doorbell_q | output | 16 | Queue index written with the notify |
| dcfg_valid | output | 1 | Device configuration access strobe |
| dcfg_write | output | 1 | Device configuration write flag |
| dcfg_size | output | 2 | Device configuration access size |
| dcfg_addr | output | AW | Rebased device configuration offset |
| dcfg_wdata | output | 32 | Device configuration write data |
| dcfg_rdata | input | 32 | Device configuration read data |

## Verification
The feature register is written with a plain mask, then with the poison bit both with and without a fallback, which separates the pass-through, substitution and zeroing paths. The per-queue registers are loaded under one selection and read under another, so that a bank shared between queues would show up. Both reset triggers are tried from a populated state and the state is read back afterwards. The same offsets 20 and 22 are accessed with message interrupts on and off, which shows whether the common/device boundary moves and whether the rebased offset is correct.

// File: rtl/pvdev_pkg.sv
package pvdev_pkg;
  localparam int OFF_HOSTF  = 0;
  localparam int OFF_GUEST  = 4;
  localparam int OFF_PFN    = 8;
  localparam int OFF_QSIZE  = 12;
  localparam int OFF_QSEL   = 14;
  localparam int OFF_NOTIFY = 16;
  localparam int OFF_STATUS = 18;
  localparam int OFF_ISR    = 19;
  localparam int OFF_CVEC   = 20;
  localparam int OFF_QVEC   = 22;

  localparam int CFG_BASE_PLAIN = 20;
  localparam int CFG_BASE_MSG   = 24;

  localparam int FEAT_NOTIFY_EMPTY = 24;
  localparam int FEAT_INDIRECT     = 28;
  localparam int FEAT_POISON       = 30;

  localparam logic [31:0] HOST_FIXED =
    (32'd1 << FEAT_NOTIFY_EMPTY) | (32'd1 << FEAT_INDIRECT) | (32'd1 << FEAT_POISON);

  localparam logic [15:0] NO_VEC = 16'hFFFF;
endpackage

// File: rtl/pvdev_qbank.sv
module pvdev_qbank import pvdev_pkg::*; #(
  parameter int NQ = 4,
  parameter int QW = 2
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [QW-1:0] sel,
  input  logic          pfn_we,
  input  logic [31:0]   pfn_wd,
  input  logic          vec_we,
  input  logic [15:0]   vec_wd,
  output logic [31:0]   pfn_rd,
  output logic [15:0]   vec_rd
);
  logic [31:0] pfn_r [NQ];
  logic [15:0] vec_r [NQ];

  for (genvar q = 0; q < NQ; q++) begin : g_q
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        pfn_r[q] <= '0;
        vec_r[q] <= NO_VEC;
      end else begin
        if (pfn_we && sel == QW'(q)) pfn_r[q] <= pfn_wd;
        if (vec_we && sel == QW'(q)) vec_r[q] <= vec_wd;
      end
    end
  end

  assign pfn_rd = pfn_r[sel];
  assign vec_rd = vec_r[sel];

  // R6: a clear leaves the selected queue at its reset values
  a_r6_bank_cleared: assert property (@(posedge clk) disable iff (rst)
    clr |=> (pfn_rd == 32'd0 && vec_rd == NO_VEC));
endmodule

// File: rtl/pvdev_isr_unit.sv
module pvdev_isr_unit (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic [7:0] set_bits,
  input  logic       rd_clr,
  output logic [7:0] isr_q
);
  always_ff @(posedge clk) begin
    if (rst || clr) isr_q <= '0;
    else            isr_q <= (rd_clr ? 8'd0 : isr_q) | set_bits;
  end

  // R8: a read with nothing newly set leaves the byte empty
  a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && set_bits == 8'd0) |=> (isr_q == 8'd0));
endmodule

// File: rtl/pvdev_regwin.sv
module pvdev_regwin import pvdev_pkg::*; #(
  parameter int AW   = 8,
  parameter int NQ   = 4,
  parameter int NVEC = 8
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [1:0]       req_size,
  input  logic [AW-1:0]    req_addr,
  input  logic [31:0]      req_wdata,
  output logic             rsp_valid,
  output logic [31:0]      rsp_rdata,
  input  logic             msg_int_en,
  input  logic [31:0]      dev_features,
  input  logic             fallback_valid,
  input  logic [31:0]      fallback_mask,
  input  logic [NQ*16-1:0] queue_sizes,
  input  logic [7:0]       intr_set,
  output logic             irq_o,
  output logic             dev_reset_o,
  output logic             doorbell_o,
  output logic [15:0]      doorbell_q,
  output logic             dcfg_valid,
  output logic             dcfg_write,
  output logic [1:0]       dcfg_size,
  output logic [AW-1:0]    dcfg_addr,
  output logic [31:0]      dcfg_wdata,
  input  logic [31:0]      dcfg_rdata
);
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1;
  localparam logic [31:0] NQ_W   = 32'(NQ);
  localparam logic [15:0] NVEC_W = 16'(NVEC);

  logic wr_en, rd_en, in_common, rst_req, clr;
  logic [AW-1:0] cfg_base;
  logic h_hostf, h_guest, h_pfn, h_qsize, h_qsel, h_notify, h_status, h_isr, h_cvec, h_qvec;

  logic [31:0]   guest_q;
  logic [QW-1:0] qsel_q;
  logic [7:0]    status_q;
  logic [15:0]   cvec_q;
  logic [7:0]    isr_q;
  logic [31:0]   pfn_rd;
  logic [15:0]   vec_rd;
  logic [31:0]   rd_mux;
  logic [15:0]   qsz [NQ];

  assign wr_en     = req_valid &  req_write;
  assign rd_en     = req_valid & ~req_write;
  assign cfg_base  = msg_int_en ? AW'(CFG_BASE_MSG) : AW'(CFG_BASE_PLAIN);
  assign in_common = req_addr < cfg_base;

  assign h_hostf  = in_common && req_addr == AW'(OFF_HOSTF);
  assign h_guest  = in_common && req_addr == AW'(OFF_GUEST);
  assign h_pfn    = in_common && req_addr == AW'(OFF_PFN);
  assign h_qsize  = in_common && req_addr == AW'(OFF_QSIZE);
  assign h_qsel   = in_common && req_addr == AW'(OFF_QSEL);
  assign h_notify = in_common && req_addr == AW'(OFF_NOTIFY);
  assign h_status = in_common && req_addr == AW'(OFF_STATUS);
  assign h_isr    = in_common && req_addr == AW'(OFF_ISR);
  assign h_cvec   = in_common && req_addr == AW'(OFF_CVEC);
  assign h_qvec   = in_common && req_addr == AW'(OFF_QVEC);

  assign rst_req = wr_en && ((h_pfn && req_wdata == 32'd0) ||
                             (h_status && req_wdata[7:0] == 8'd0));
  assign clr = rst_req;

  function automatic logic [15:0] vclamp(input logic [15:0] v);
    return (v < NVEC_W) ? v : NO_VEC;
  endfunction

  for (genvar q = 0; q < NQ; q++) begin : g_qsz
    assign qsz[q] = queue_sizes[q*16 +: 16];
  end

  pvdev_qbank #(.NQ(NQ), .QW(QW)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr),
    .sel    (qsel_q),
    .pfn_we (wr_en && h_pfn && req_wdata != 32'd0),
    .pfn_wd (req_wdata),
    .vec_we (wr_en && h_qvec),
    .vec_wd (vclamp(req_wdata[15:0])),
    .pfn_rd (pfn_rd),
    .vec_rd (vec_rd)
  );

  pvdev_isr_unit u_isr (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .set_bits (intr_set),
    .rd_clr   (rd_en && h_isr),
    .isr_q    (isr_q)
  );

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      guest_q  <= '0;
      qsel_q   <= '0;
      status_q <= '0;
      cvec_q   <= NO_VEC;
    end else if (wr_en) begin
      if (h_guest)
        guest_q <= req_wdata[FEAT_POISON] ? (fallback_valid ? fallback_mask : 32'd0) : req_wdata;
      if (h_qsel && req_wdata < NQ_W) qsel_q <= req_wdata[QW-1:0];
      if (h_status) status_q <= req_wdata[7:0];
      if (h_cvec)   cvec_q   <= vclamp(req_wdata[15:0]);
    end
  end

  always_comb begin
    rd_mux = '1;
    if (!in_common)    rd_mux = dcfg_rdata;
    else if (h_hostf)  rd_mux = dev_features | HOST_FIXED;
    else if (h_guest)  rd_mux = guest_q;
    else if (h_pfn)    rd_mux = pfn_rd;
    else if (h_qsize)  rd_mux = {16'd0, qsz[qsel_q]};
    else if (h_qsel)   rd_mux = 32'(qsel_q);
    else if (h_status) rd_mux = {24'd0, status_q};
    else if (h_isr)    rd_mux = {24'd0, isr_q};
    else if (h_cvec)   rd_mux = {16'd0, cvec_q};
    else if (h_qvec)   rd_mux = {16'd0, vec_rd};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      dev_reset_o <= 1'b0;
      doorbell_o  <= 1'b0;
      doorbell_q  <= '0;
    end else begin
      rsp_valid   <= rd_en;
      rsp_rdata   <= rd_mux;
      dev_reset_o <= rst_req;
      doorbell_o  <= wr_en && h_notify;
      if (wr_en && h_notify) doorbell_q <= req_wdata[15:0];
    end
  end

  assign irq_o      = isr_q[0] & ~msg_int_en;
  assign dcfg_valid = req_valid & ~in_common;
  assign dcfg_write = req_write;
  assign dcfg_size  = req_size;
  assign dcfg_addr  = req_addr - cfg_base;
  assign dcfg_wdata = req_wdata;

  // R6 / R7: the reset pulse coincides with the cleared state
  a_r7_reset_state: assert property (@(posedge clk) disable iff (rst)
    dev_reset_o |-> (status_q == 8'd0 && qsel_q == '0 && guest_q == 32'd0 && cvec_q == NO_VEC));
  // R9: a doorbell only follows a write to the notify offset
  a_r9_doorbell_src: assert property (@(posedge clk) disable iff (rst)
    doorbell_o |-> $past(wr_en && h_notify));
  // R4: the selection never leaves the queue range
  a_r4_qsel_range: assert property (@(posedge clk) disable iff (rst)
    32'(qsel_q) < NQ_W);
  // R13: a response only follows a read
  a_r13_rsp_after_read: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(rd_en));
  // R12: forwarded accesses touch no common-area side effect
  a_r12_fwd_isolated: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !in_common) |=> (!doorbell_o && !dev_reset_o));
endmodule

// File: tb/tb_pvdev_regwin.sv
module tb_pvdev_regwin;
  localparam int AW = 8, NQ = 4, NVEC = 8;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0;
  logic [1:0] req_size = 2;
  logic [AW-1:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic rsp_valid;
  logic [31:0] rsp_rdata;
  logic msg_int_en = 1;
  logic [31:0] dev_features = 32'h0000_00A5;
  logic fallback_valid = 1;
  logic [31:0] fallback_mask = 32'h0000_0033;
  logic [NQ*16-1:0] queue_sizes = {16'h0400, 16'h0300, 16'h0200, 16'h0100};
  logic [7:0] intr_set = 0;
  logic irq_o, dev_reset_o, doorbell_o, dcfg_valid, dcfg_write;
  logic [15:0] doorbell_q;
  logic [1:0] dcfg_size;
  logic [AW-1:0] dcfg_addr;
  logic [31:0] dcfg_wdata, dcfg_rdata;

  assign dcfg_rdata = {16'hC0DE, 8'h00, dcfg_addr};

  always #5 clk = ~clk;

  pvdev_regwin #(.AW(AW), .NQ(NQ), .NVEC(NVEC)) dut (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) chk("R13 unexpected response", 32'd1, 32'd0);
      else chk(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
    end
  end

  task automatic drive(input logic w, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d; req_size = 2;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    drive(1'b1, a, d);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    drive(1'b0, a, 32'd0);
  endtask

  task automatic fwd(input logic w, input logic [7:0] a, input logic [31:0] d,
                     input logic [7:0] ea, input string tag);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d; req_size = 1;
    #1;
    chk({tag, " valid"}, 32'(dcfg_valid), 32'd1);
    chk({tag, " addr"}, 32'(dcfg_addr), 32'(ea));
    chk({tag, " write"}, 32'(dcfg_write), 32'(w));
    chk({tag, " size"}, 32'(dcfg_size), 32'd1);
    if (w) chk({tag, " wdata"}, dcfg_wdata, d);
    else begin exp_q.push_back({16'hC0DE, 8'h00, ea}); tag_q.push_back({tag, " rdata"}); end
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic pulse_isr(input logic [7:0] b);
    @(negedge clk); intr_set = b;
    @(negedge clk); intr_set = 0;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 dev_reset_o", 32'(dev_reset_o), 0);
    chk("R1 doorbell_o", 32'(doorbell_o), 0);
    chk("R1 irq_o", 32'(irq_o), 0);
    rd(4, 0, "R1 guest");
    rd(14, 0, "R1 qsel");
    rd(18, 0, "R1 status");
    rd(19, 0, "R1 isr");
    rd(8, 0, "R1 pfn");
    rd(20, 32'hFFFF, "R1 cvec");
    rd(22, 32'hFFFF, "R1 qvec");
    // R2 host features
    rd(0, 32'h5100_00A5, "R2 host features");
    wr(0, 32'h0);
    rd(0, 32'h5100_00A5, "R2 host write ignored");
    // R3 guest features
    wr(4, 32'h1234_5678);
    chk("R13 no response to write", 32'(rsp_valid), 0);
    rd(4, 32'h1234_5678, "R3 guest plain");
    wr(4, 32'h4000_0001);
    rd(4, 32'h0000_0033, "R3 poison with fallback");
    fallback_valid = 0;
    wr(4, 32'h4000_0001);
    rd(4, 32'h0, "R3 poison no fallback");
    wr(4, 32'h1234_5678);
    // R4 queue select
    wr(14, 2);
    rd(14, 2, "R4 qsel accepted");
    wr(14, 4);
    rd(14, 2, "R4 qsel equal NQ ignored");
    wr(14, 32'h0001_0001);
    rd(14, 2, "R4 qsel wide value ignored");
    // R5 per-queue state
    wr(8, 32'h000A_BCDE);
    rd(8, 32'h000A_BCDE, "R5 pfn q2");
    rd(12, 32'h0300, "R5 qsize q2");
    wr(22, 5);
    rd(22, 5, "R5 qvec q2");
    wr(14, 1);
    rd(8, 0, "R5 pfn q1");
    rd(12, 32'h0200, "R5 qsize q1");
    rd(22, 32'hFFFF, "R5 qvec q1");
    wr(14, 2);
    rd(8, 32'h000A_BCDE, "R5 pfn q2 kept");
    // R10 vectors
    wr(22, 9);
    rd(22, 32'hFFFF, "R10 qvec out of range");
    wr(20, 3);
    rd(20, 3, "R10 cvec");
    wr(20, 8);
    rd(20, 32'hFFFF, "R10 cvec equal NVEC");
    // R7 status and reset
    wr(18, 32'h107);
    rd(18, 7, "R7 status low byte");
    wr(18, 32'h100);
    chk("R7 reset pulse", 32'(dev_reset_o), 1);
    @(negedge clk);
    chk("R7 reset pulse ends", 32'(dev_reset_o), 0);
    rd(4, 0, "R7 guest cleared");
    rd(14, 0, "R7 qsel cleared");
    rd(18, 0, "R7 status cleared");
    wr(14, 2);
    rd(8, 0, "R7 pfn q2 cleared");
    rd(22, 32'hFFFF, "R7 qvec q2 cleared");
    // R6 frame-number zero reset
    wr(8, 32'h55);
    wr(18, 3);
    wr(20, 3);
    wr(8, 0);
    chk("R6 reset pulse", 32'(dev_reset_o), 1);
    rd(20, 32'hFFFF, "R6 cvec cleared");
    rd(18, 0, "R6 status cleared");
    rd(14, 0, "R6 qsel cleared");
    wr(14, 2);
    rd(8, 0, "R6 pfn cleared");
    // R8 interrupt status
    msg_int_en = 0;
    pulse_isr(8'h03);
    chk("R8 irq level", 32'(irq_o), 1);
    pulse_isr(8'h04);
    rd(19, 7, "R8 isr accumulates");
    chk("R8 irq after clear", 32'(irq_o), 0);
    rd(19, 0, "R8 isr cleared by read");
    msg_int_en = 1;
    pulse_isr(8'h01);
    chk("R8 irq masked in message mode", 32'(irq_o), 0);
    rd(19, 1, "R8 isr in message mode");
    // R9 doorbell
    wr(16, 32'hFFFF_0003);
    chk("R9 doorbell pulse", 32'(doorbell_o), 1);
    chk("R9 doorbell index", 32'(doorbell_q), 3);
    @(negedge clk);
    chk("R9 doorbell one cycle", 32'(doorbell_o), 0);
    // R11 unmapped and read-only
    rd(16, 32'hFFFF_FFFF, "R11 notify read");
    rd(1, 32'hFFFF_FFFF, "R11 offset 1");
    rd(13, 32'hFFFF_FFFF, "R11 offset 13");
    rd(17, 32'hFFFF_FFFF, "R11 offset 17");
    rd(23, 32'hFFFF_FFFF, "R11 offset 23");
    wr(12, 0);
    rd(12, 32'h0300, "R11 qsize write ignored");
    wr(19, 32'hFF);
    rd(19, 0, "R11 isr write ignored");
    wr(5, 32'hFF);
    rd(4, 0, "R11 offset 5 write ignored");
    // R12 device configuration forwarding
    fwd(1'b0, 24, 0, 0, "R12 msg read 24");
    fwd(1'b1, 30, 32'hDEAD_BEEF, 6, "R12 msg write 30");
    msg_int_en = 0;
    fwd(1'b0, 20, 0, 0, "R12 plain read 20");
    fwd(1'b0, 22, 0, 2, "R12 plain read 22");
    msg_int_en = 1;
    rd(20, 32'hFFFF, "R12 cvec back in common");
    repeat (3) @(negedge clk);
    chk("R13 all responses seen", 32'(exp_q.size()), 0);
    done = 1;
    summary();
  end
endmodule